// File: doc/BRIEF.md
# Static Memory Read Strobe Sequencer

This block turns a single read request into the pin timing an asynchronous static memory expects. Once a request is taken, it latches the address and the target bank, lowers that bank's chip select, waits a programmable setup time, drives an active-low read strobe for a programmable pulse time, keeps the chip select low for a programmable hold time, and then releases the bus. The data returned by the memory is captured at the clock edge that ends the strobe pulse. Setup and pulse lengths have half-cycle resolution: the strobe falls on the falling clock edge, half a cycle after its phase begins.

Each bank has its own timing word. When the previous access left data-float cycles pending and the new access goes to a different bank, the block does not add those cycles to the new bank's setup. It inserts whichever of the two is longer. A bank can also be set to an early-read mode, in which setup and hold shaping are skipped. A setup/hold/wait-state combination that the memory interface cannot run correctly is refused and reported through an error flag.

Top module: `sram_rd_seq`

## Requirements
- R1: After a request is accepted in the idle state, the phases run in the order float, setup, pulse, hold. `rdy_o` rises after F + S + (PW + 2) + H cycles, counted from the accepting edge. F, S and H are the inserted float, setup and hold cycles, and PW is the pulse field. The chip select is already released when `rdy_o` is high.
- R2: The setup field (timing word bits [2:0]) is 0 for no setup phase. A value of 1 to 7 gives setup + 0.5 cycles between the chip select falling and the strobe falling. With no setup phase, that gap is 0.5 cycle.
- R3: The pulse field (bits [9:3], 0 to 127) holds the strobe low for PW + 1.5 cycles.
- R4: The hold field (bits [12:10], 0 to 7) keeps the chip select low for that many whole cycles after the strobe rises.
- R5: When the early-read bit (bit 18) is set, the setup and hold fields have no effect. Both are treated as zero.
- R6: Setup field nonzero, hold field zero, wait-state bit (bit 17) clear, and early-read bit clear is an illegal combination. The block then raises `err_o` together with `rdy_o` on the cycle after acceptance. No chip select and no strobe are driven, and the pending float count is left unchanged.
- R7: `rdata_o` takes the `mem_data_i` value present just before the edge that ends the pulse. It holds that value until the next completed access.
- R8: At most one chip select is low, and only the selected bank's. The strobe is low only while a chip select is low. `mem_addr_o` does not change while a chip select stays low.
- R9: A pending float count F, from the float field (bits [16:13]) of the last completed bank, applies only if the new bank differs from that bank. If F is not less than the effective setup S, F float cycles run with every chip select high, and no setup phase runs.
- R10: If the effective setup S is greater than the pending F of a different bank, no float cycles are inserted and the full setup is used.
- R11: An access to the same bank as the last one, or with F equal to zero, gets no float or chip-select-change cycles.
- R12: `rdy_o` is a one-cycle pulse. A request held high, or inputs that change, while an access is running start nothing and leave the latched address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Read request, taken only when idle |
| addr_i | input | AW | Read address |
| bank_i | input | BW | Target bank index |
| cfg_i | input | NBANK*19 | Per-bank timing words, bank i at bits [19*i +: 19] |
| rdy_o | output | 1 | Access complete, one-cycle pulse |
| err_o | output | 1 | Illegal timing word refused, valid with rdy_o |
| rdata_o | output | DW | Captured read data |
| mem_addr_o | output | AW | Address to memory |
| mem_cs_no | output | NBANK | Active-low chip selects |
| mem_rd_no | output | 1 | Active-low read strobe |
| mem_data_i | input | DW | Data from memory |

## Verification
Directed accesses cover four bank-change patterns: same bank with float pending, a different bank whose float count exceeds the setup, a different bank whose setup exceeds the float count, and a pending count of zero. Each pattern lands on a different branch of the float-versus-setup choice, and measuring the total latency tells them apart. Further directed cases cover early read with large setup and hold fields, the illegal combination, and the longest pulse with maximum setup and hold. These separate the half-cycle strobe placement from whole-cycle errors. Random timing words and random banks, with the request sometimes held high and the inputs scrambled during an access, exercise how the phases chain and how the address is held. They are checked by sampling the pins twice per cycle.

// File: rtl/sram_rd_pkg.sv
// Shared types for the static memory read sequencer.
// Assumes timing fields sized to the ranges stated in the brief.
package sram_rd_pkg;
    localparam int SET_W = 3;
    localparam int PUL_W = 7;
    localparam int HLD_W = 3;
    localparam int FLT_W = 4;
    localparam int CNT_W = PUL_W + 1;

    // Per-bank timing word, LSB first: setup, pulse, hold, float, wait, early
    typedef struct packed {
        logic             early;
        logic             wsen;
        logic [FLT_W-1:0] flt;
        logic [HLD_W-1:0] hold;
        logic [PUL_W-1:0] pulse;
        logic [SET_W-1:0] setup;
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);

    typedef enum logic [2:0] {
        PH_IDLE, PH_FLOAT, PH_SETUP, PH_PULSE, PH_HOLD, PH_DONE
    } phase_t;

    // Phase lengths in whole cycles, decided at acceptance
    typedef struct packed {
        logic [FLT_W-1:0] flt;
        logic [SET_W-1:0] setup;
        logic [CNT_W-1:0] pulse;
        logic [HLD_W-1:0] hold;
        logic             err;
    } plan_t;
endpackage

// File: rtl/sram_rd_plan.sv
// Turns the selected bank's timing word and the pending float state into
// phase lengths. Purely combinational; assumes inputs stable at acceptance.
module sram_rd_plan
    import sram_rd_pkg::*;
#(
    parameter int BW = 2
) (
    input  logic [SET_W-1:0] setup_i,
    input  logic [PUL_W-1:0] pulse_i,
    input  logic [HLD_W-1:0] hold_i,
    input  logic             wsen_i,
    input  logic             early_i,
    input  logic [BW-1:0]    bank_i,
    input  logic [BW-1:0]    pend_bank_i,
    input  logic [FLT_W-1:0] pend_flt_i,
    output plan_t            plan_o
);
    logic [SET_W-1:0] s_eff;
    logic [FLT_W-1:0] f_eff;

    // Apply early-read, legality and float-versus-setup arbitration
    always_comb begin
        s_eff        = early_i ? '0 : setup_i;
        f_eff        = (bank_i != pend_bank_i) ? pend_flt_i : '0;
        plan_o.err   = !early_i && (setup_i != '0) && (hold_i == '0) && !wsen_i;
        plan_o.pulse = {1'b0, pulse_i} + CNT_W'(2);
        plan_o.hold  = early_i ? '0 : hold_i;
        if ((f_eff != '0) && (f_eff >= {1'b0, s_eff})) begin
            plan_o.flt   = f_eff;
            plan_o.setup = '0;
        end else begin
            plan_o.flt   = '0;
            plan_o.setup = s_eff;
        end
    end
endmodule

// File: rtl/sram_rd_fsm.sv
// Phase sequencer: steps idle, float, setup, pulse, hold, done, skipping
// zero-length phases. Latches the plan on acceptance; each phase counter is
// loaded with its length minus one.
module sram_rd_fsm
    import sram_rd_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   req_i,
    input  plan_t  plan_i,
    output phase_t phase_o,
    output logic   accept_o,
    output logic   pulse_last_o,
    output logic   err_q_o
);
    phase_t           ph, ph_nx;
    plan_t            lat, src;
    logic [CNT_W-1:0] cnt, cnt_nx;

    function automatic logic [CNT_W-1:0] len_of(phase_t p, plan_t q);
        case (p)
            PH_FLOAT: len_of = CNT_W'(q.flt);
            PH_SETUP: len_of = CNT_W'(q.setup);
            PH_PULSE: len_of = q.pulse;
            PH_HOLD:  len_of = CNT_W'(q.hold);
            default:  len_of = CNT_W'(1);
        endcase
    endfunction

    // Next phase and counter value
    always_comb begin
        src   = (ph == PH_IDLE) ? plan_i : lat;
        ph_nx = ph;
        case (ph)
            PH_IDLE:
                if (req_i) begin
                    if (plan_i.err)            ph_nx = PH_DONE;
                    else if (plan_i.flt != '0) ph_nx = PH_FLOAT;
                    else if (plan_i.setup != '0) ph_nx = PH_SETUP;
                    else                       ph_nx = PH_PULSE;
                end
            PH_FLOAT: if (cnt == '0) ph_nx = (lat.setup != '0) ? PH_SETUP : PH_PULSE;
            PH_SETUP: if (cnt == '0) ph_nx = PH_PULSE;
            PH_PULSE: if (cnt == '0) ph_nx = (lat.hold != '0) ? PH_HOLD : PH_DONE;
            PH_HOLD:  if (cnt == '0) ph_nx = PH_DONE;
            default:  ph_nx = PH_IDLE;
        endcase
        if (ph_nx != ph)        cnt_nx = len_of(ph_nx, src) - CNT_W'(1);
        else if (ph == PH_IDLE) cnt_nx = cnt;
        else                    cnt_nx = cnt - CNT_W'(1);
    end

    // Phase, counter and plan registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ph  <= PH_IDLE;
            cnt <= '0;
            lat <= '0;
        end else begin
            ph  <= ph_nx;
            cnt <= cnt_nx;
            if (ph == PH_IDLE && req_i) lat <= plan_i;
        end
    end

    assign phase_o      = ph;
    assign accept_o     = (ph == PH_IDLE) && req_i;
    assign pulse_last_o = (ph == PH_PULSE) && (cnt == '0);
    assign err_q_o      = lat.err;
endmodule

// File: rtl/sram_rd_strobe.sv
// Half-cycle strobe shaper: the strobe falls on the falling clock edge after
// the pulse phase starts and rises on the rising edge that ends it.
// Assumes the pulse phase lasts at least two cycles.
module sram_rd_strobe (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic in_pulse_i,
    output logic rd_no
);
    logic half_q;

    // Falling-edge copy of the pulse phase
    always_ff @(negedge clk_i) begin
        if (!rst_ni) half_q <= 1'b0;
        else         half_q <= in_pulse_i;
    end

    assign rd_no = ~(in_pulse_i & half_q);
endmodule

// File: rtl/sram_rd_seq.sv
// Top of the static memory read sequencer. Latches address and bank on
// acceptance, drives one chip select per bank, captures data at the end of
// the pulse and records the float count left behind for the next access.
// Assumes cfg_i stays stable for the duration of an access.
module sram_rd_seq
    import sram_rd_pkg::*;
#(
    parameter int AW    = 23,
    parameter int DW    = 16,
    parameter int NBANK = 4,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   req_i,
    input  logic [AW-1:0]          addr_i,
    input  logic [BW-1:0]          bank_i,
    input  logic [NBANK*CFG_W-1:0] cfg_i,
    output logic                   rdy_o,
    output logic                   err_o,
    output logic [DW-1:0]          rdata_o,
    output logic [AW-1:0]          mem_addr_o,
    output logic [NBANK-1:0]       mem_cs_no,
    output logic                   mem_rd_no,
    input  logic [DW-1:0]          mem_data_i
);
    bank_cfg_t        cfg_arr [NBANK];
    bank_cfg_t        sel_cfg;
    plan_t            plan;
    phase_t           phase;
    logic             accept, pulse_last, err_q, bus_on;
    logic [AW-1:0]    addr_q;
    logic [BW-1:0]    bank_q, pend_bank;
    logic [DW-1:0]    rdata_q;
    logic [FLT_W-1:0] pend_flt;

    for (genvar g = 0; g < NBANK; g++) begin : g_cfg
        assign cfg_arr[g] = cfg_i[g*CFG_W +: CFG_W];
    end
    assign sel_cfg = cfg_arr[bank_i];

    sram_rd_plan #(.BW(BW)) u_plan (
        .setup_i    (sel_cfg.setup),
        .pulse_i    (sel_cfg.pulse),
        .hold_i     (sel_cfg.hold),
        .wsen_i     (sel_cfg.wsen),
        .early_i    (sel_cfg.early),
        .bank_i     (bank_i),
        .pend_bank_i(pend_bank),
        .pend_flt_i (pend_flt),
        .plan_o     (plan)
    );

    sram_rd_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (req_i),
        .plan_i      (plan),
        .phase_o     (phase),
        .accept_o    (accept),
        .pulse_last_o(pulse_last),
        .err_q_o     (err_q)
    );

    sram_rd_strobe u_strobe (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .in_pulse_i(phase == PH_PULSE),
        .rd_no     (mem_rd_no)
    );

    // Access registers: address, bank, read data, pending float
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            addr_q    <= '0;
            bank_q    <= '0;
            rdata_q   <= '0;
            pend_flt  <= '0;
            pend_bank <= '0;
        end else begin
            if (accept) begin
                addr_q <= addr_i;
                bank_q <= bank_i;
            end
            if (pulse_last) rdata_q <= mem_data_i;
            if (phase == PH_DONE && !err_q) begin
                pend_flt  <= cfg_arr[bank_q].flt;
                pend_bank <= bank_q;
            end
        end
    end

    assign bus_on = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);

    for (genvar b = 0; b < NBANK; b++) begin : g_cs
        assign mem_cs_no[b] = !(bus_on && (bank_q == BW'(b)));
    end

    assign rdy_o      = (phase == PH_DONE);
    assign err_o      = (phase == PH_DONE) && err_q;
    assign rdata_o    = rdata_q;
    assign mem_addr_o = addr_q;
endmodule

// File: rtl/sram_rd_chk.sv
// Pin-level properties of the read sequencer, bound to every instance.
module sram_rd_chk #(
    parameter int AW    = 23,
    parameter int NBANK = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             rdy_o,
    input logic             err_o,
    input logic [AW-1:0]    mem_addr_o,
    input logic [NBANK-1:0] mem_cs_no,
    input logic             mem_rd_no
);
    p_cs_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~mem_cs_no));

    p_strobe_in_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_rd_no |-> !(&mem_cs_no));

    p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(&mem_cs_no) && !(&$past(mem_cs_no))) |-> $stable(mem_addr_o));

    p_err_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (rdy_o && (&mem_cs_no) && mem_rd_no));

    p_rdy_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdy_o |=> !rdy_o);

    p_cs_off_at_rdy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdy_o |-> (&mem_cs_no));
endmodule

bind sram_rd_seq sram_rd_chk #(.AW(AW), .NBANK(NBANK)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rdy_o     (rdy_o),
    .err_o     (err_o),
    .mem_addr_o(mem_addr_o),
    .mem_cs_no (mem_cs_no),
    .mem_rd_no (mem_rd_no)
);

// File: tb/sram_rd_seq_test.sv
module sram_rd_seq_test;
    localparam int AW = 23, DW = 16, NBANK = 4, BW = 2, CW = 19;

    logic                clk = 1'b0, rst_ni = 1'b0, req_i = 1'b0;
    logic [AW-1:0]       addr_i = '0;
    logic [BW-1:0]       bank_i = '0;
    logic [NBANK*CW-1:0] cfg_i = '0;
    logic                rdy_o, err_o, mem_rd_no;
    logic [DW-1:0]       rdata_o, mem_data_i;
    logic [AW-1:0]       mem_addr_o;
    logic [NBANK-1:0]    mem_cs_no;

    int checks = 0, fails = 0;
    int n_pre, n_lo, n_post, n_bad;
    int pend_f = 0, pend_b = 0;
    logic [AW-1:0] exp_addr = '0;
    int  exp_bank = 0;
    bit  seen_lo, done = 1'b0;
    logic [DW-1:0] last_data = '0;

    always #5 clk = ~clk;

    sram_rd_seq uut (.clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
        .bank_i(bank_i), .cfg_i(cfg_i), .rdy_o(rdy_o), .err_o(err_o), .rdata_o(rdata_o),
        .mem_addr_o(mem_addr_o), .mem_cs_no(mem_cs_no), .mem_rd_no(mem_rd_no),
        .mem_data_i(mem_data_i));

    function automatic logic [DW-1:0] data_of(logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A5A ^ {9'b0, a[22:16]};
    endfunction

    // memory model: valid data only while the strobe is low (R7)
    assign mem_data_i = mem_rd_no ? 16'hDEAD : data_of(mem_addr_o);

    function automatic logic [CW-1:0] mk(bit early, bit wsen, int flt, int hold, int pul, int set);
        return {early, wsen, 4'(flt), 3'(hold), 7'(pul), 3'(set)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // half-cycle pin monitor
    always @(clk) begin
        #1;
        if (!(&mem_cs_no)) begin
            if (mem_cs_no != ~(NBANK'(1) << exp_bank)) n_bad++;
            if (mem_addr_o != exp_addr) n_bad++;
            if (!mem_rd_no) begin n_lo++; seen_lo = 1'b1; end
            else if (!seen_lo) n_pre++;
            else n_post++;
        end else if (!mem_rd_no) n_bad++;
    end

    task automatic run(input int bank, input logic [AW-1:0] addr, input bit hold_req);
        logic [CW-1:0] c;
        int set, pul, hld, flt, s, h, fp, fi, si, t_exp, n;
        bit early, wsen, err;
        c = cfg_i[bank*CW +: CW];
        set = int'(c[2:0]); pul = int'(c[9:3]); hld = int'(c[12:10]);
        flt = int'(c[16:13]); wsen = c[17]; early = c[18];
        err = !early && set != 0 && hld == 0 && !wsen;
        s = early ? 0 : set;
        h = early ? 0 : hld;
        fp = (bank != pend_b) ? pend_f : 0;
        if (fp != 0 && fp >= s) begin fi = fp; si = 0; end else begin fi = 0; si = s; end
        t_exp = err ? 0 : fi + si + pul + 2 + h;
        @(negedge clk);
        req_i = 1'b1; bank_i = BW'(bank); addr_i = addr;
        exp_bank = bank; exp_addr = addr;
        n_pre = 0; n_lo = 0; n_post = 0; n_bad = 0; seen_lo = 1'b0;
        @(posedge clk);
        n = 0;
        forever begin
            @(negedge clk);
            if (rdy_o || n > 400) break;
            n++;
            req_i = hold_req;
            addr_i = AW'($urandom); bank_i = BW'($urandom);
        end
        req_i = 1'b0;
        check(n == t_exp, "R1 latency (R9/R10/R11 float-vs-setup)", n, t_exp);
        check(err_o == err, "R6 error flag", int'(err_o), int'(err));
        if (!err) last_data = data_of(addr);
        check(rdata_o == last_data, "R7 captured data", int'(rdata_o), int'(last_data));
        check(n_pre == (err ? 0 : 2*si + 1), "R2 setup half-cycles", n_pre, err ? 0 : 2*si + 1);
        check(n_lo == (err ? 0 : 2*pul + 3), "R3 strobe half-cycles", n_lo, err ? 0 : 2*pul + 3);
        check(n_post == 2*h*(err ? 0 : 1), "R4/R5 hold half-cycles", n_post, err ? 0 : 2*h);
        check(n_bad == 0, "R8 chip select and address", n_bad, 0);
        @(negedge clk);
        check(!rdy_o && (&mem_cs_no), "R12 no restart after ready", int'(rdy_o), 0);
        if (!err) begin pend_f = flt; pend_b = bank; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!rdy_o && !err_o, "R12 reset ready low", int'(rdy_o), 0);
        check((&mem_cs_no) && mem_rd_no, "R8 reset bus idle", int'(mem_cs_no), 15);
        rst_ni = 1'b1;
        // directed corners
        cfg_i[0*CW +: CW] = mk(0, 1, 5, 1, 3, 2);
        run(0, 23'h000123, 0);                          // R11 zero pending
        cfg_i[1*CW +: CW] = mk(0, 1, 0, 2, 1, 3);
        run(1, 23'h100456, 0);                          // R9 float 5 >= setup 3
        cfg_i[2*CW +: CW] = mk(0, 0, 2, 1, 0, 6);
        run(2, 23'h2ABCDE, 1);                          // R11 float 0, R12 req held
        cfg_i[3*CW +: CW] = mk(0, 1, 6, 1, 2, 4);
        run(3, 23'h055555, 0);                          // R10 setup 4 > float 2
        run(3, 23'h0AAAAA, 0);                          // R11 same bank, float 6 pending
        cfg_i[0*CW +: CW] = mk(1, 0, 1, 5, 2, 5);
        run(0, 23'h7FFFFF, 0);                          // R5 early read
        cfg_i[1*CW +: CW] = mk(0, 0, 3, 0, 2, 3);
        run(1, 23'h000001, 0);                          // R6 illegal combination
        cfg_i[2*CW +: CW] = mk(0, 1, 15, 7, 127, 7);
        run(2, 23'h31337F, 0);                          // R3 longest pulse
        cfg_i[0*CW +: CW] = mk(0, 0, 0, 0, 0, 0);
        run(0, 23'h012345, 0);                          // R2 no setup, legal
        // random mix
        for (int i = 0; i < 60; i++) begin
            for (int b = 0; b < NBANK; b++)
                cfg_i[b*CW +: CW] = mk(($urandom % 6) == 0, $urandom % 2, $urandom % 16,
                                       $urandom % 8, $urandom % 10, $urandom % 8);
            run($urandom % NBANK, AW'($urandom), $urandom % 2);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule